// File: doc/BRIEF.md
# Paired 8-bit Timer with Trigger Gating and Pulse Capture

This block holds two 8-bit up-counters. Each runs on its own or the two join into one 16-bit timer. A counter advances only in system clock cycles where its chosen clock-enable source is high. The source is one of eight `tick_src` bits. When the count equals the channel's match value, the counter returns to zero, raises a one-cycle interrupt and inverts its toggle output. In auto-reload mode it keeps running after that. In one-shot mode it halts.

Software starts and stops each counter with single-cycle pulses. Each channel can also take one of several external trigger lines. The trigger passes through a two-flop synchroniser and a minimum-width filter. In gated mode, an accepted high level starts the counter and an accepted low level stops it. In pulse-measure mode, the counter runs only while the accepted trigger level is high. On the accepted falling edge, the count moves into a capture register and the counter clears. That gives the width of each pulse in ticks.

Top module: `pair_timer`

## Requirements
- R1: During and after synchronous reset, `count`, `capture`, `irq`, `tog`, `running` and `cap_valid` are all zero.
- R2: A running channel adds one to its count at each clock edge where its selected tick source is high and no match or capture occurs. Otherwise the count holds.
- R3: If a running channel sees a tick while its count equals its match value (byte k of `match_val`, bits [8k+7:8k]) outside pulse-measure mode, the count goes to zero. In the same edge, `irq[k]` is high for exactly one cycle and `tog[k]` inverts. In auto-reload mode `running[k]` stays high.
- R4: With `one_shot[k]` high, the match in R3 also clears `running[k]`, so the count stays at zero and no further interrupt follows until the channel is started again.
- R5: A pulse on `sw_start[k]` sets `running[k]` at the next edge and a pulse on `sw_stop[k]` clears it. When a stop cause and a start cause coincide, the stop wins.
- R6: The trigger for channel k is `trig_in[trig_sel[2k+1:2k]]`. It passes through two synchroniser flops, and a new level is accepted only after the synchronised value has differed from the accepted level for 3 consecutive cycles. A 2-cycle pulse is ignored and a 3-cycle pulse is accepted.
- R7: With `trig_gate[k]` high, an accepted rise sets `running[k]` and an accepted fall clears it.
- R8: With `pulse_meas[k]` high, the channel starts and stops as in R7. On an accepted fall, the current count loads into `capture`, `cap_valid[k]` pulses for one cycle and the count clears. No interrupt is raised. With every tick high, a trigger held for H cycles yields a capture of H-1.
- R9: With `pair_mode` high, channel 0's controls drive a 16-bit counter. `count[7:0]` advances on each tick and `count[15:8]` advances when the low byte wraps from 0xFF. The match compares all 16 bits of `match_val`, and the match and capture results appear only on `irq[1]`, `tog[1]` and `cap_valid[1]`. Channel 1's own controls are ignored and `running[1]` stays zero.
- R10: Channel k takes its tick from `tick_src[clk_sel[3k+2:3k]]`. Selecting a source that stays low freezes a running counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| tick_src | input | 8 | candidate clock-enable sources |
| trig_in | input | 4 | asynchronous external trigger lines |
| pair_mode | input | 1 | join both channels into one 16-bit timer |
| sw_start | input | 2 | per-channel start pulse |
| sw_stop | input | 2 | per-channel stop pulse |
| clk_sel | input | 6 | tick source index, 3 bits per channel |
| trig_sel | input | 4 | trigger line index, 2 bits per channel |
| one_shot | input | 2 | halt after the first match |
| trig_gate | input | 2 | trigger levels start and stop the counter |
| pulse_meas | input | 2 | pulse-width measurement mode |
| match_val | input | 16 | match value, byte k for channel k |
| irq | output | 2 | one-cycle match interrupt per channel |
| tog | output | 2 | toggles on every match |
| running | output | 2 | run state per channel |
| count | output | 16 | counter values, byte k for channel k |
| capture | output | 16 | captured pulse widths, byte k for channel k |
| cap_valid | output | 2 | one-cycle capture strobe |

## Verification
A wrong run bit shows up as a count that is frozen or moving one edge after the fault. A stuck filter counter shows up as a `running` change that arrives early or late relative to the trigger. A wrong cascade carry shows up as an upper byte that departs from the expected value within one wrap of the low byte, at most 256 ticks. A misplaced capture shows up as a `capture` value off by one tick on the first measured pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_PULSE   = 2'd2
    } run_mode_e;

    // Per-channel decision for one clock edge.
    typedef struct packed {
        logic start;
        logic stop;
        logic inc;
        logic clr;
        logic hit;
        logic cap;
    } step_t;

    function automatic run_mode_e pick_mode(input logic oneshot, input logic pulse);
        if (pulse)
            return MODE_PULSE;
        else if (oneshot)
            return MODE_ONESHOT;
        else
            return MODE_RELOAD;
    endfunction

    function automatic step_t chan_step(
        input logic      run,
        input logic      tick,
        input logic      gate,
        input logic      rise,
        input logic      fall,
        input logic      go,
        input logic      halt,
        input logic      at_match,
        input run_mode_e mode
    );
        step_t s;
        logic  en;
        en      = run & tick;
        s.cap   = (mode == MODE_PULSE) & fall;
        s.hit   = en & (mode != MODE_PULSE) & at_match;
        s.clr   = s.cap | s.hit;
        s.inc   = en & ~s.clr;
        s.stop  = halt | (gate & fall) | (s.hit & (mode == MODE_ONESHOT));
        s.start = go | (gate & rise);
        return s;
    endfunction

    function automatic logic next_run(input logic run, input step_t s);
        if (s.stop)
            return 1'b0;
        else if (s.start)
            return 1'b1;
        else
            return run;
    endfunction

endpackage

// File: rtl/tmr_trig_filter.sv
module tmr_trig_filter #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int FC_W = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic            s1;
    logic            s2;
    logic [FC_W-1:0] fc;
    logic            upd;

    assign upd  = (s2 != lvl) && (fc == FC_W'(HOLD - 1));
    assign rise = upd & s2;
    assign fall = upd & ~s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            lvl <= 1'b0;
            fc  <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == lvl) begin
                fc <= '0;
            end else if (upd) begin
                lvl <= s2;
                fc  <= '0;
            end else begin
                fc <= fc + FC_W'(1);
            end
        end
    end

    // An accepted level always agrees with the synchronised samples before it.
    AST_FILTER_AGREE: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> (lvl == $past(s2))); // R6

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + W'(1);
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt)); // R2

endmodule

// File: rtl/pair_timer.sv
module pair_timer
    import tmr_pkg::*;
#(
    parameter  int CNT_W  = 8,
    parameter  int N_SRC  = 8,
    parameter  int N_TRIG = 4,
    parameter  int HOLD   = 3,
    localparam int SEL_W  = $clog2(N_SRC),
    localparam int TSEL_W = $clog2(N_TRIG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        tick_src,
    input  logic [N_TRIG-1:0]       trig_in,
    input  logic                    pair_mode,
    input  logic [NCH-1:0]          sw_start,
    input  logic [NCH-1:0]          sw_stop,
    input  logic [NCH*SEL_W-1:0]    clk_sel,
    input  logic [NCH*TSEL_W-1:0]   trig_sel,
    input  logic [NCH-1:0]          one_shot,
    input  logic [NCH-1:0]          trig_gate,
    input  logic [NCH-1:0]          pulse_meas,
    input  logic [NCH*CNT_W-1:0]    match_val,
    output logic [NCH-1:0]          irq,
    output logic [NCH-1:0]          tog,
    output logic [NCH-1:0]          running,
    output logic [NCH*CNT_W-1:0]    count,
    output logic [NCH*CNT_W-1:0]    capture,
    output logic [NCH-1:0]          cap_valid
);
    logic [SEL_W-1:0]  csel [NCH];
    logic [TSEL_W-1:0] tsel [NCH];
    logic [CNT_W-1:0]  mval [NCH];
    logic [CNT_W-1:0]  cnt  [NCH];
    logic [CNT_W-1:0]  cap_q [NCH];

    logic [NCH-1:0] lvl, rise, fall;
    logic [NCH-1:0] inc, clr;
    logic [NCH-1:0] run_q, run_d;
    logic [NCH-1:0] irq_q, irq_d;
    logic [NCH-1:0] cv_q, cv_d;
    logic [NCH-1:0] tog_q;
    logic [NCH-1:0] cap_ld;

    run_mode_e mode [NCH];
    step_t     st   [NCH];
    logic [NCH-1:0] tick, at_match;

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_ch
            assign csel[k] = clk_sel[k*SEL_W +: SEL_W];
            assign tsel[k] = trig_sel[k*TSEL_W +: TSEL_W];
            assign mval[k] = match_val[k*CNT_W +: CNT_W];

            tmr_trig_filter #(.HOLD(HOLD)) i_filt (
                .clk  (clk),
                .rst  (rst),
                .raw  (trig_in[tsel[k]]),
                .lvl  (lvl[k]),
                .rise (rise[k]),
                .fall (fall[k])
            );

            tmr_count #(.W(CNT_W)) i_cnt (
                .clk (clk),
                .rst (rst),
                .inc (inc[k]),
                .clr (clr[k]),
                .cnt (cnt[k])
            );

            assign count[k*CNT_W +: CNT_W]   = cnt[k];
            assign capture[k*CNT_W +: CNT_W] = cap_q[k];

            // After a match the counter sits at zero.
            AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
                irq_q[k] |-> (cnt[k] == '0)); // R3

            // After a capture the counter restarts from zero.
            AST_CAPTURE_CLEAR: assert property (@(posedge clk) disable iff (rst)
                cv_q[k] |-> (cnt[k] == '0)); // R8
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            mode[i]     = pick_mode(one_shot[i], pulse_meas[i]);
            tick[i]     = tick_src[csel[i]];
            at_match[i] = pair_mode ? ({cnt[1], cnt[0]} == {mval[1], mval[0]})
                                    : (cnt[i] == mval[i]);
            st[i] = chan_step(run_q[i], tick[i],
                              trig_gate[i] | (mode[i] == MODE_PULSE),
                              rise[i], fall[i], sw_start[i], sw_stop[i],
                              at_match[i], mode[i]);
        end
        if (pair_mode) begin
            inc[0]    = st[0].inc;
            clr[0]    = st[0].clr;
            inc[1]    = st[0].inc & (&cnt[0]);
            clr[1]    = st[0].clr;
            run_d[0]  = next_run(run_q[0], st[0]);
            run_d[1]  = 1'b0;
            irq_d     = {st[0].hit, 1'b0};
            cv_d      = {st[0].cap, 1'b0};
            cap_ld    = {NCH{st[0].cap}};
        end else begin
            for (int i = 0; i < NCH; i++) begin
                inc[i]    = st[i].inc;
                clr[i]    = st[i].clr;
                run_d[i]  = next_run(run_q[i], st[i]);
                irq_d[i]  = st[i].hit;
                cv_d[i]   = st[i].cap;
                cap_ld[i] = st[i].cap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            irq_q <= '0;
            cv_q  <= '0;
            tog_q <= '0;
            for (int i = 0; i < NCH; i++) cap_q[i] <= '0;
        end else begin
            run_q <= run_d;
            irq_q <= irq_d;
            cv_q  <= cv_d;
            tog_q <= tog_q ^ irq_d;
            for (int i = 0; i < NCH; i++) begin
                if (cap_ld[i]) cap_q[i] <= cnt[i];
            end
        end
    end

    assign irq       = irq_q;
    assign tog       = tog_q;
    assign running   = run_q;
    assign cap_valid = cv_q;

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
        (irq_d[0] && one_shot[0]) |=> !run_q[0]); // R4

    AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        sw_stop[0] |=> !run_q[0]); // R5

    AST_PAIR_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        pair_mode |=> (!irq_q[0] && !cv_q[0] && !run_q[1])); // R9

endmodule

// File: tb/test_pair_timer.sv
module test_pair_timer;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_N     = 3;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  tick_src;
    logic [3:0]  trig_in;
    logic        pair_mode;
    logic [1:0]  sw_start, sw_stop;
    logic [5:0]  clk_sel;
    logic [3:0]  trig_sel;
    logic [1:0]  one_shot, trig_gate, pulse_meas;
    logic [15:0] match_val;
    logic [1:0]  irq, tog, running, cap_valid;
    logic [15:0] count, capture;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_timer i_pair_timer (
        .clk(clk), .rst(rst), .tick_src(tick_src), .trig_in(trig_in),
        .pair_mode(pair_mode), .sw_start(sw_start), .sw_stop(sw_stop),
        .clk_sel(clk_sel), .trig_sel(trig_sel), .one_shot(one_shot),
        .trig_gate(trig_gate), .pulse_meas(pulse_meas), .match_val(match_val),
        .irq(irq), .tog(tog), .running(running), .count(count),
        .capture(capture), .cap_valid(cap_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model, built from the requirements ----------
    logic [1:0] m_s1, m_s2, m_lvl, m_run, m_irq, m_tog, m_cv;
    int         m_fc [2];
    logic [7:0] m_c [2];
    logic [7:0] m_cap [2];
    logic [1:0] t_rise, t_fall, t_en, t_hit, t_cap, t_start, t_stop, t_am;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_irq = 0; m_tog = 0; m_cv = 0;
            for (int k = 0; k < 2; k++) begin
                m_fc[k] = 0; m_c[k] = 0; m_cap[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                t_rise[k] = 0; t_fall[k] = 0;
                if (m_s2[k] != m_lvl[k] && m_fc[k] == HOLD_N - 1) begin
                    t_rise[k] = m_s2[k];
                    t_fall[k] = !m_s2[k];
                end
                if (m_s2[k] == m_lvl[k]) m_fc[k] = 0;
                else if (m_fc[k] == HOLD_N - 1) begin m_lvl[k] = m_s2[k]; m_fc[k] = 0; end
                else m_fc[k] = m_fc[k] + 1;
                m_s2[k] = m_s1[k];
                m_s1[k] = trig_in[trig_sel[2*k +: 2]];

                t_am[k]    = pair_mode ? ({m_c[1], m_c[0]} == match_val)
                                       : (m_c[k] == match_val[8*k +: 8]);
                t_en[k]    = m_run[k] & tick_src[clk_sel[3*k +: 3]];
                t_cap[k]   = pulse_meas[k] & t_fall[k];
                t_hit[k]   = t_en[k] & !pulse_meas[k] & t_am[k];
                t_stop[k]  = sw_stop[k] | ((trig_gate[k] | pulse_meas[k]) & t_fall[k])
                           | (t_hit[k] & one_shot[k] & !pulse_meas[k]);
                t_start[k] = sw_start[k] | ((trig_gate[k] | pulse_meas[k]) & t_rise[k]);
            end
            m_irq = 0; m_cv = 0;
            if (!pair_mode) begin
                for (int k = 0; k < 2; k++) begin
                    if (t_cap[k]) begin m_cap[k] = m_c[k]; m_cv[k] = 1; m_c[k] = 0; end
                    else if (t_hit[k]) begin m_c[k] = 0; m_irq[k] = 1; m_tog[k] = !m_tog[k]; end
                    else if (t_en[k]) m_c[k] = m_c[k] + 8'd1;
                    m_run[k] = t_stop[k] ? 1'b0 : (t_start[k] ? 1'b1 : m_run[k]);
                end
            end else begin
                if (t_cap[0]) begin
                    m_cap[0] = m_c[0]; m_cap[1] = m_c[1]; m_cv[1] = 1; m_c[0] = 0; m_c[1] = 0;
                end else if (t_hit[0]) begin
                    m_c[0] = 0; m_c[1] = 0; m_irq[1] = 1; m_tog[1] = !m_tog[1];
                end else if (t_en[0]) begin
                    if (m_c[0] == 8'hFF) m_c[1] = m_c[1] + 8'd1;
                    m_c[0] = m_c[0] + 8'd1;
                end
                m_run[0] = t_stop[0] ? 1'b0 : (t_start[0] ? 1'b1 : m_run[0]);
                m_run[1] = 1'b0;
            end
        end
    end

    // ---------------- continuous comparison and monitors --------------------
    int irq0_n, irq1_n, cv1_n, cv0_n;
    bit run0_seen, upper_seen;

    always @(negedge clk) begin
        if (!rst) begin
            chk(count === {m_c[1], m_c[0]}, "R2 count", {16'h0, count}, {16'h0, m_c[1], m_c[0]});
            chk({irq, tog} === {m_irq, m_tog}, "R3 irq/tog", {28'h0, irq, tog}, {28'h0, m_irq, m_tog});
            chk(running === m_run, "R5 running", {30'h0, running}, {30'h0, m_run});
            chk({capture, cap_valid} === {m_cap[1], m_cap[0], m_cv}, "R8 capture",
                {14'h0, capture, cap_valid}, {14'h0, m_cap[1], m_cap[0], m_cv});
            if (irq[0]) irq0_n++;
            if (irq[1]) irq1_n++;
            if (cap_valid[0]) cv0_n++;
            if (cap_valid[1]) cv1_n++;
            if (running[0]) run0_seen = 1;
            if (count[15:8] != 0) upper_seen = 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ------------------------------------
    task automatic clear_mon();
        #1;
        irq0_n = 0; irq1_n = 0; cv0_n = 0; cv1_n = 0; run0_seen = 0; upper_seen = 0;
    endtask

    task automatic idle_inputs();
        tick_src = 8'h01; trig_in = 0; pair_mode = 0; sw_start = 0; sw_stop = 0;
        clk_sel = 0; trig_sel = 0; one_shot = 0; trig_gate = 0; pulse_meas = 0;
        match_val = 16'hFFFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk({count, capture, irq, tog, running, cap_valid} === 40'h0, "R1 reset state",
            {count, irq, tog, running, cap_valid}, 32'h0);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_start(input logic [1:0] which);
        @(negedge clk); sw_start = which;
        @(negedge clk); sw_start = 0;
    endtask

    task automatic trig_pulse(input int len);
        @(negedge clk); trig_in[0] = 1'b1;
        repeat (len) @(negedge clk);
        trig_in[0] = 1'b0;
    endtask

    task automatic rand_cycle();
        @(negedge clk);
        tick_src[0] = 1'b1;
        tick_src[1] = 1'b0;
        for (int j = 2; j < 8; j++) tick_src[j] = ($urandom_range(7) < j);
        for (int i = 0; i < 4; i++) if ($urandom_range(11) == 0) trig_in[i] = ~trig_in[i];
        sw_start = {($urandom_range(63) == 0), ($urandom_range(63) == 0)};
        sw_stop  = {($urandom_range(127) == 0), ($urandom_range(127) == 0)};
    endtask

    // ---------------- test sequence ------------------------------------------
    initial begin
        void'($urandom(32'h5EED));
        rst = 1;
        idle_inputs();

        // R1 reset and R10 dead tick source
        do_reset();
        clk_sel = 6'b001_000;               // channel 1 uses source 1 (always low)
        pulse_start(2'b10);
        wait_n(30);
        chk(running[1] === 1'b1, "R10 channel running on dead source", {31'h0, running[1]}, 1);
        chk(count[15:8] === 8'h00, "R10 count frozen on dead source", {24'h0, count[15:8]}, 0);

        // R4 one-shot on channel 0
        do_reset();
        clear_mon();
        one_shot = 2'b01; match_val = 16'hFF05;
        pulse_start(2'b01);
        wait_n(25);
        chk(running[0] === 1'b0, "R4 one-shot halted", {31'h0, running[0]}, 0);
        chk(count[7:0] === 8'h00, "R4 one-shot count at zero", {24'h0, count[7:0]}, 0);
        chk(irq0_n == 1, "R4 single interrupt", irq0_n, 1);

        // R6 filter boundary and R7 gating
        do_reset();
        clear_mon();
        trig_gate = 2'b01;
        trig_pulse(2);
        wait_n(10);
        chk(run0_seen == 0, "R6 two-cycle pulse ignored", {31'h0, run0_seen}, 0);
        clear_mon();
        trig_pulse(3);
        wait_n(10);
        chk(run0_seen == 1, "R6 three-cycle pulse accepted", {31'h0, run0_seen}, 1);
        chk(running[0] === 1'b0, "R7 accepted fall stops", {31'h0, running[0]}, 0);
        @(negedge clk); trig_in[0] = 1'b1;
        wait_n(8);
        chk(running[0] === 1'b1, "R7 accepted rise starts", {31'h0, running[0]}, 1);
        trig_in[0] = 1'b0;
        wait_n(8);
        chk(running[0] === 1'b0, "R7 level low stops", {31'h0, running[0]}, 0);

        // R8 pulse width capture with every tick high
        do_reset();
        clear_mon();
        pulse_meas = 2'b01;
        trig_pulse(9);
        wait_n(12);
        chk(capture[7:0] === 8'd8, "R8 captured width", {24'h0, capture[7:0]}, 8);
        chk(cv0_n == 1, "R8 single capture strobe", cv0_n, 1);
        chk(count[7:0] === 8'd0, "R8 counter cleared after capture", {24'h0, count[7:0]}, 0);
        chk(irq0_n == 0, "R8 no interrupt in pulse mode", irq0_n, 0);

        // R9 paired 16-bit timer, match 0x0103 -> period 260 ticks
        do_reset();
        clear_mon();
        pair_mode = 1'b1; match_val = 16'h0103;
        clk_sel = 6'b001_000;               // channel 1 select must not matter
        @(negedge clk); sw_start = 2'b11;
        @(negedge clk); sw_start = 2'b00;
        repeat (698) @(negedge clk);
        #1;
        chk(irq1_n == 2, "R9 paired interrupt count", irq1_n, 2);
        chk(irq0_n == 0, "R9 low half interrupt quiet", irq0_n, 0);
        chk(upper_seen == 1, "R9 carry into upper byte", {31'h0, upper_seen}, 1);
        chk(running[1] === 1'b0, "R9 channel 1 run ignored", {31'h0, running[1]}, 0);

        // R5 stop beats start
        do_reset();
        @(negedge clk); sw_start = 2'b01; sw_stop = 2'b01;
        @(negedge clk); sw_start = 0; sw_stop = 0;
        #1;
        chk(running[0] === 1'b0, "R5 stop wins over start", {31'h0, running[0]}, 0);

        // constrained random episodes, checked by the model every cycle
        for (int ep = 0; ep < 30; ep++) begin
            do_reset();
            @(negedge clk);
            pair_mode  = ($urandom_range(2) == 0);
            clk_sel    = 6'($urandom);
            trig_sel   = 4'($urandom);
            one_shot   = 2'($urandom);
            trig_gate  = 2'($urandom);
            pulse_meas = ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00;
            match_val  = {8'($urandom_range(2)), 8'($urandom_range(20))};
            if (!pair_mode) match_val[15:8] = 8'($urandom_range(20));
            for (int c = 0; c < 1500; c++) rand_cycle();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule